// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address from a CPU memory request into a 52-bit physical address. Each request is first compared against an eight-entry fully associative translation cache. A hit answers on the next cycle and does not touch memory. A miss starts a walk through four levels of tables in memory. Each level is reached through a single read port that sends an address and receives a 64-bit entry. Each table is indexed by its own 9-bit slice of the virtual address.

Software loads the frame number of the top-level table into a root register. Software can also invalidate every cached translation with a flush pulse. When a walk completes, its mapping goes into the cache in rotating slot order. If any fetched entry has its present bit clear, the walk ends at once and a fault is reported in place of a translation. Only one translation is handled at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `done`, `fault` and `rd_valid` are 0.
- R2: A request whose virtual page number, bits 47:12, matches a valid cache entry raises `done` with `fault`=0 in the cycle after acceptance. It issues no memory read, and `pa` is the cached 40-bit frame number followed by `req_va[11:0]`.
- R3: On a miss, the first read address is `root_pfn`·4096 + `req_va[47:39]`·8.
- R4: Reads two to four use the frame number from bits 51:12 of the previous entry, times 4096, plus 8 times the index. The indices are taken from bits 38:30, 29:21 and 20:12 in that order.
- R5: A walk in which all four entries have bit 0 (present) set produces `pa` = {leaf bits 51:12, va[11:0]} with `done`=1 and `fault`=0. These appear one cycle after the fourth response.
- R6: An entry with bit 0 clear at any level ends the walk with no further reads. `done` and `fault` are both 1 one cycle after that response. The cache is not written, so the same request walks again.
- R7: A successful walk stores its mapping, so a later request in the same 4 KiB page hits.
- R8: The cache holds 8 entries that are filled in round-robin order. The ninth distinct fill evicts the oldest entry, and the other entries keep hitting.
- R9: A `flush` pulse invalidates all entries, so the next request walks. A request accepted in the same cycle as `flush` is treated as a miss.
- R10: `req_ready` stays 0 from acceptance of a miss until `done`. While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_addr` hold.
- R11: `root_we` loads `root_pfn` into the root register. Walks started afterwards begin at the new root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| root_we | input | 1 | Load strobe for the root register |
| root_pfn | input | 40 | Frame number of the top-level table |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 48 | Virtual address to translate |
| rd_valid | output | 1 | Memory read request |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 52 | Physical address of the entry to read |
| rsp_valid | input | 1 | Read data present |
| rsp_data | input | 64 | Table entry read from memory |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Page fault, valid with `done` |
| pa | output | 52 | Translated physical address, valid with `done` and `fault`=0 |

## Verification
A cache hit presents `done` and `pa` right after the accepting edge. The bench therefore expects zero extra cycles between acceptance and completion on a hit. The bench memory answers each read two edges after the handshake, so each level costs three cycles. That puts a full walk's result twelve cycles after acceptance and a fault at level L at 3·L+3 cycles. The bench counts falling edges from acceptance and compares the count against these figures, adding the stall cycles when it holds `rd_ready` low. It samples every output on the falling edge, half a cycle after the register that drives it has settled.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 9,
  parameter int LEVELS  = 4,
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_we,
  input  logic [PA_W-13:0]  root_pfn,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [PA_W-1:0]   rd_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic              fault,
  output logic [PA_W-1:0]   pa
);

  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PFN_W   = PA_W - OFF_W;
  localparam int RR_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ENT_SH  = 3;
  localparam int PRESENT = 0;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t               st_q;
  logic [PFN_W-1:0]  root_q;
  logic [PFN_W-1:0]  base_q;
  logic [VA_W-1:0]   va_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [RR_W-1:0]   rr_q;
  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]  tag_q [ENTRIES];
  logic [PFN_W-1:0]  frm_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [PFN_W-1:0]  hit_pfn;
  logic [IDX_W-1:0]  idx;
  logic              accept, hit_any, last_lvl, present, fill_en;

  wire unused_bits = ^{rsp_data[DATA_W-1:PA_W], rsp_data[OFF_W-1:1]};

  assign req_ready = (st_q == S_IDLE);
  assign rd_valid  = (st_q == S_REQ);
  assign accept    = req_valid && req_ready;
  assign last_lvl  = (lvl_q == LVL_W'(LEVELS - 1));
  assign present   = rsp_data[PRESENT];
  assign fill_en   = (st_q == S_WAIT) && rsp_valid && present && last_lvl;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = vld_q[g] && (tag_q[g] == req_va[VA_W-1:OFF_W]);
    end
  endgenerate

  assign hit_any = (|hit_vec) && !flush;

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_pfn = hit_pfn | frm_q[i];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < LEVELS; k++)
      if (lvl_q == LVL_W'(k))
        idx = va_q[OFF_W + (LEVELS - 1 - k) * IDX_W +: IDX_W];
  end

  assign rd_addr = {base_q, {OFF_W{1'b0}}} + (PA_W'(idx) << ENT_SH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      root_q <= '0;
      base_q <= '0;
      va_q   <= '0;
      lvl_q  <= '0;
      rr_q   <= '0;
      vld_q  <= '0;
      done   <= 1'b0;
      fault  <= 1'b0;
      pa     <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (root_we) root_q <= root_pfn;
      case (st_q)
        S_IDLE: if (accept) begin
          if (hit_any) begin
            done <= 1'b1;
            pa   <= {hit_pfn, req_va[OFF_W-1:0]};
          end else begin
            va_q   <= req_va;
            base_q <= root_q;
            lvl_q  <= '0;
            st_q   <= S_REQ;
          end
        end
        S_REQ: if (rd_ready) st_q <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (!present) begin
            done  <= 1'b1;
            fault <= 1'b1;
            st_q  <= S_IDLE;
          end else if (last_lvl) begin
            done <= 1'b1;
            pa   <= {rsp_data[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
            vld_q[rr_q] <= 1'b1;
            rr_q <= (rr_q == RR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            st_q <= S_IDLE;
          end else begin
            base_q <= rsp_data[PA_W-1:OFF_W];
            lvl_q  <= lvl_q + 1'b1;
            st_q   <= S_REQ;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if (flush) vld_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[rr_q] <= va_q[VA_W-1:OFF_W];
      frm_q[rr_q] <= rsp_data[PA_W-1:OFF_W];
    end
  end

  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit_any) |=> (done && !fault && !rd_valid));

  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (done && !fault && pa[OFF_W-1:0] == $past(va_q[OFF_W-1:0])));

  a_r6_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  a_r6_no_fill_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_WAIT) && rsp_valid && !present && !flush) |=> (fault && $stable(vld_q)));

  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r10_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  a_r10_busy_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT) |-> (!req_ready && !done));

endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        root_we = 0;
  logic [39:0] root_pfn = '0;
  logic        flush = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic        rd_valid;
  logic        rd_ready = 1;
  logic [51:0] rd_addr;
  logic        rsp_valid = 0;
  logic [63:0] rsp_data = '0;
  logic        done, fault;
  logic [51:0] pa;

  int checks = 0, errors = 0, rd_cnt = 0, cyc = 0;
  logic [51:0] rd_log [0:63];
  logic        pend = 0;
  logic [51:0] pend_addr = '0;
  logic [63:0] mem [logic [51:0]];

  pt_walker u0 (.clk(clk), .rst_n(rst_n), .root_we(root_we), .root_pfn(root_pfn),
    .flush(flush), .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .fault(fault), .pa(pa));

  always #4 clk = ~clk;

  function automatic logic [63:0] rd_mem(input logic [51:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_valid <= 1'b0;
    if (pend) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mem(pend_addr);
      pend      <= 1'b0;
    end
    if (rd_valid && rd_ready) begin
      pend      <= 1'b1;
      pend_addr <= rd_addr;
      rd_log[rd_cnt[5:0]] <= rd_addr;
      rd_cnt    <= rd_cnt + 1;
    end
  end

  function automatic logic [51:0] ea(input logic [39:0] base, input logic [8:0] idx);
    return {base, 12'h000} + {40'd0, idx, 3'b000};
  endfunction

  function automatic logic [39:0] tbl(input int lv, input logic [39:0] root, input logic [47:0] va);
    case (lv)
      0: return root;
      1: return {4'h1, 19'd0, root[7:0], va[47:39]};
      2: return {4'h2, 10'd0, root[7:0], va[47:30]};
      default: return {4'h3, 1'd0, root[7:0], va[47:21]};
    endcase
  endfunction

  function automatic logic [8:0] vidx(input int lv, input logic [47:0] va);
    return va[39 - lv*9 +: 9];
  endfunction

  task automatic map_page(input logic [39:0] root, input logic [47:0] va, input logic [39:0] pfn);
    for (int lv = 0; lv < 3; lv++)
      mem[ea(tbl(lv, root, va), vidx(lv, va))] = {12'h0, tbl(lv + 1, root, va), 12'h001};
    mem[ea(tbl(3, root, va), vidx(3, va))] = {12'h0, pfn, 12'h001};
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xlate(input logic [47:0] va, output logic [51:0] pa_o, output bit flt,
                       output int n, output int nrd, output int first, output bit busy_ok);
    first = rd_cnt;
    busy_ok = 1;
    @(negedge clk);
    req_valid = 1; req_va = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!done && n < 300) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      n++;
    end
    pa_o = pa; flt = fault;
    nrd = rd_cnt - first;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic load_root(input logic [39:0] r);
    @(negedge clk); root_we = 1; root_pfn = r;
    @(negedge clk); root_we = 0;
  endtask

  localparam logic [39:0] ROOT1 = 40'h00_0000_0077;
  localparam logic [39:0] ROOT2 = 40'h00_0000_0A5C;
  localparam logic [47:0] VA_A  = 48'h1234_5678_9ABC;
  localparam logic [39:0] PFN_A = 40'hAB_CDE0_1234;
  localparam logic [39:0] PFN_A2 = 40'h31_4159_2653;

  logic [51:0] r_pa;
  bit r_f, r_busy;
  int r_n, r_rd, r_first;

  task automatic t_reset();
    chk(req_ready === 1'b1, "R1", "req_ready", 64'(req_ready), 1);
    chk(done === 1'b0 && fault === 1'b0, "R1", "done/fault", {62'd0, done, fault}, 0);
    chk(rd_valid === 1'b0, "R1", "rd_valid", 64'(rd_valid), 0);
  endtask

  task automatic t_walk();
    map_page(ROOT1, VA_A, PFN_A);
    xlate(VA_A, r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(r_rd == 4, "R3", "walk read count", r_rd, 4);
    chk(rd_log[r_first[5:0]] == ea(ROOT1, VA_A[47:39]), "R3", "first read addr",
        rd_log[r_first[5:0]], ea(ROOT1, VA_A[47:39]));
    for (int lv = 1; lv < 4; lv++)
      chk(rd_log[6'(r_first + lv)] == ea(tbl(lv, ROOT1, VA_A), vidx(lv, VA_A)), "R4",
          "level read addr", rd_log[6'(r_first + lv)], ea(tbl(lv, ROOT1, VA_A), vidx(lv, VA_A)));
    chk(r_pa == {PFN_A, VA_A[11:0]} && !r_f, "R5", "walk pa", r_pa, {PFN_A, VA_A[11:0]});
    chk(r_n == 12, "R5", "walk latency", r_n, 12);
    chk(r_busy, "R10", "ready low during walk", 0, 1);
  endtask

  task automatic t_hit();
    logic [47:0] va = {VA_A[47:12], 12'h345};
    xlate(va, r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(r_rd == 0, "R2", "hit reads", r_rd, 0);
    chk(r_n == 0 && !r_f, "R2", "hit latency", r_n, 0);
    chk(r_pa == {PFN_A, 12'h345}, "R7", "cached pa", r_pa, {PFN_A, 12'h345});
  endtask

  task automatic t_fault();
    logic [47:0] vb = {VA_A[47:21], ~VA_A[20:12], 12'h010};
    logic [47:0] vc = {~VA_A[47:39], VA_A[38:0]};
    xlate(vb, r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(r_f && r_rd == 4 && r_n == 12, "R6", "leaf fault", {r_f, 31'd0, r_rd}, {1'b1, 31'd0, 32'd4});
    xlate(vc, r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(r_f && r_rd == 1, "R6", "top fault reads", r_rd, 1);
    chk(r_n == 3, "R6", "top fault latency", r_n, 3);
    xlate(vb, r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(r_f && r_rd == 4, "R6", "fault not cached", r_rd, 4);
  endtask

  task automatic t_stall();
    logic [51:0] a0;
    bit held = 1;
    int n, first;
    do_flush();
    first = rd_cnt;
    @(negedge clk);
    rd_ready = 0; req_valid = 1; req_va = VA_A;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    a0 = rd_addr;
    n = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); n++;
      if (!(rd_valid && rd_addr == a0)) held = 0;
    end
    rd_ready = 1;
    while (!done && n < 300) begin @(negedge clk); n++; end
    chk(held, "R10", "read held under stall", 0, 1);
    chk(n == 15 && pa == {PFN_A, VA_A[11:0]}, "R10", "stalled walk latency", n, 15);
    chk(rd_cnt - first == 4, "R9", "walk after flush", rd_cnt - first, 4);
  endtask

  task automatic t_flush();
    xlate(VA_A, r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(r_rd == 0, "R7", "hit before flush", r_rd, 0);
    do_flush();
    xlate(VA_A, r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(r_rd == 4 && r_pa == {PFN_A, VA_A[11:0]}, "R9", "miss after flush", r_rd, 4);
  endtask

  function automatic logic [47:0] pva(input int k);
    return {9'h055, 9'h011, 9'h022, 9'(k), 12'h010};
  endfunction

  task automatic t_rr();
    do_flush();
    for (int k = 0; k < 9; k++) map_page(ROOT1, pva(k), 40'h50_0000_0000 + 40'(k));
    for (int k = 0; k < 9; k++) xlate(pva(k), r_pa, r_f, r_n, r_rd, r_first, r_busy);
    xlate(pva(0), r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(r_rd == 4, "R8", "oldest evicted", r_rd, 4);
    xlate(pva(2), r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(r_rd == 0 && r_pa == {40'h50_0000_0002, 12'h010}, "R8", "neighbour kept", r_pa,
        {40'h50_0000_0002, 12'h010});
    xlate(pva(1), r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(r_rd == 4, "R8", "next oldest evicted", r_rd, 4);
    xlate(pva(8), r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(r_rd == 0, "R8", "newest kept", r_rd, 0);
  endtask

  task automatic t_root();
    map_page(ROOT2, VA_A, PFN_A2);
    load_root(ROOT2);
    do_flush();
    xlate(VA_A, r_pa, r_f, r_n, r_rd, r_first, r_busy);
    chk(rd_log[r_first[5:0]] == ea(ROOT2, VA_A[47:39]), "R11", "new root addr",
        rd_log[r_first[5:0]], ea(ROOT2, VA_A[47:39]));
    chk(r_pa == {PFN_A2, VA_A[11:0]} && !r_f, "R11", "new root pa", r_pa, {PFN_A2, VA_A[11:0]});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    load_root(ROOT1);
    t_walk();
    t_hit();
    t_fault();
    t_flush();
    t_stall();
    t_rr();
    t_root();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule